// File: doc/BRIEF.md
# Dual-Window Result Monitor

This block sits beside a converter and watches each result as it completes. A result arrives as a one-cycle valid strobe with a 4-bit channel number and a 16-bit value. Two independent window units each watch one selected channel. Each unit compares the value against its own lower and upper limit and reports either an excursion outside the window or an entry into it, depending on its mode. Outside mode counts a value equal to a limit as inside. Inside mode counts a value equal to a limit as outside.

A third outcome combines the two unit outcomes with OR, AND or XOR. It is evaluated at the moment unit 1 takes a result. It uses unit 0's outcome from that same cycle when unit 0 also compares then, and otherwise unit 0's most recent outcome. When the units watch different channels, the scan order must therefore convert unit 0's channel before unit 1's. All three outcomes land in sticky flags that can be cleared one by one. An interrupt line reports any flag whose enable bit is set.

Top module: `awd_dual_monitor`

## Requirements
- R1: After a synchronous reset, all three flags and the interrupt are 0 and unit 0's remembered outcome is 0.
- R2: A unit in outside mode (mode bit 0) reports a hit when value > upper or value < lower. A value equal to either limit is not a hit.
- R3: A unit in inside mode (mode bit 1) reports a hit only when lower < value < upper. A value equal to either limit is not a hit.
- R4: A unit compares only in a cycle where the valid strobe is high, its enable bit is set (bit 0 for unit 0, bit 1 for unit 1) and the strobe's channel equals its selected channel. Otherwise its flag and the combined flag are unchanged by that cycle.
- R5: The flags are `flags[0]` for unit 0, `flags[1]` for unit 1 and `flags[2]` for the combination. Each stays set until its own bit of `flag_clr` is pulsed, and clearing one bit leaves the others untouched.
- R6: When a hit and a clear reach the same flag in the same cycle, the flag ends up set.
- R7: Combine code `cfg_comb` selects the function: 2'b01 OR, 2'b10 AND, 2'b11 XOR. 2'b00 never sets `flags[2]`.
- R8: The combination is evaluated only in cycles where unit 1 compares. It uses unit 0's result from the same cycle if unit 0 compares then, and otherwise unit 0's latest result.
- R9: `irq` equals the OR over i of `flags[i]` AND `irq_en[i]`, with `irq_en` taken from the same clock edge that loads the flags.
- R10: Flags and `irq` change on the clock edge that samples the strobe or clear, and are visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | One-cycle strobe marking a finished result |
| res_chan | input | 4 | Channel number of the result |
| res_value | input | 16 | Result value |
| cfg_unit_en | input | 2 | Compare enable per unit |
| cfg_mode | input | 2 | Per unit: 0 outside window, 1 inside window |
| cfg_chan0 | input | 4 | Channel watched by unit 0 |
| cfg_chan1 | input | 4 | Channel watched by unit 1 |
| cfg_lo0 | input | 16 | Unit 0 lower limit |
| cfg_hi0 | input | 16 | Unit 0 upper limit |
| cfg_lo1 | input | 16 | Unit 1 lower limit |
| cfg_hi1 | input | 16 | Unit 1 upper limit |
| cfg_comb | input | 2 | Combine function code |
| irq_en | input | 3 | Interrupt enable per flag |
| flag_clr | input | 3 | Clear pulse per flag |
| flags | output | 3 | Sticky flags: unit 0, unit 1, combination |
| irq | output | 1 | Interrupt request |

## Verification
Each result strobe and each clear pulse is sampled at one rising edge, and the flags and interrupt it produces are due right after that edge, one cycle later. An interrupt-enable change shows on `irq` after the next edge. The bench drives every input on the falling edge and advances its reference model at the rising edge from the same held inputs. It compares flags and interrupt at the next falling edge, so each result is checked exactly one cycle after its stimulus. Directed steps hit the limit values, same-cycle set and clear, stale versus same-cycle unit 0 outcomes, and every combine code. A randomised run then clusters values around the limits.

// File: rtl/awd_pkg.sv
package awd_pkg;
  typedef enum logic [1:0] {
    COMB_OFF = 2'b00,
    COMB_OR  = 2'b01,
    COMB_AND = 2'b10,
    COMB_XOR = 2'b11
  } comb_fn_e;

  typedef enum logic {
    WIN_OUTSIDE = 1'b0,
    WIN_INSIDE  = 1'b1
  } win_mode_e;

  localparam int NUM_UNITS = 2;
  localparam int NUM_FLAGS = NUM_UNITS + 1;
endpackage

// File: rtl/awd_window_unit.sv
module awd_window_unit #(
  parameter int DATA_W = 16,
  parameter int CH_W   = 4
) (
  input  logic              res_valid,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [DATA_W-1:0] res_value,
  input  logic              en,
  input  logic              mode,
  input  logic [CH_W-1:0]   chan_sel,
  input  logic [DATA_W-1:0] lim_lo,
  input  logic [DATA_W-1:0] lim_hi,
  output logic              fire,
  output logic              hit
);
  import awd_pkg::*;

  logic above_hi, below_lo, strictly_in;

  always_comb begin
    fire        = res_valid && en && (res_chan == chan_sel);
    above_hi    = res_value > lim_hi;
    below_lo    = res_value < lim_lo;
    strictly_in = (res_value > lim_lo) && (res_value < lim_hi);
    if (win_mode_e'(mode) == WIN_INSIDE)
      hit = fire && strictly_in;
    else
      hit = fire && (above_hi || below_lo);
  end
endmodule

// File: rtl/awd_combiner.sv
module awd_combiner (
  input  logic       clk,
  input  logic       rst,
  input  logic       fire0,
  input  logic       hit0,
  input  logic       fire1,
  input  logic       hit1,
  input  logic [1:0] fn,
  output logic       comb_set
);
  import awd_pkg::*;

  logic u0_last;
  logic u0_view;

  always_ff @(posedge clk) begin
    if (rst)
      u0_last <= 1'b0;
    else if (fire0)
      u0_last <= hit0;
  end

  always_comb begin
    u0_view = fire0 ? hit0 : u0_last;
    unique case (comb_fn_e'(fn))
      COMB_OR:  comb_set = fire1 && (u0_view || hit1);
      COMB_AND: comb_set = fire1 && (u0_view && hit1);
      COMB_XOR: comb_set = fire1 && (u0_view ^ hit1);
      default:  comb_set = 1'b0;
    endcase
  end
endmodule

// File: rtl/awd_flag_bank.sv
module awd_flag_bank #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_in,
  input  logic [NF-1:0] clr,
  input  logic [NF-1:0] en,
  output logic [NF-1:0] flags_q,
  output logic          irq_q
);
  logic [NF-1:0] flags_d;

  always_comb flags_d = (flags_q & ~clr) | set_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_q   <= |(flags_d & en);
    end
  end

  for (genvar i = 0; i < NF; i++) begin : g_chk
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flags_q[i] && !clr[i]) |=> flags_q[i]); // R5
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !set_in[i]) |=> !flags_q[i]); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_in[i] |=> flags_q[i]); // R6
  end

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(flags_q & $past(en))); // R9
endmodule

// File: rtl/awd_dual_monitor.sv
module awd_dual_monitor #(
  parameter int DATA_W = 16,
  parameter int NUM_CH = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      res_valid,
  input  logic [$clog2(NUM_CH)-1:0] res_chan,
  input  logic [DATA_W-1:0]         res_value,
  input  logic [1:0]                cfg_unit_en,
  input  logic [1:0]                cfg_mode,
  input  logic [$clog2(NUM_CH)-1:0] cfg_chan0,
  input  logic [$clog2(NUM_CH)-1:0] cfg_chan1,
  input  logic [DATA_W-1:0]         cfg_lo0,
  input  logic [DATA_W-1:0]         cfg_hi0,
  input  logic [DATA_W-1:0]         cfg_lo1,
  input  logic [DATA_W-1:0]         cfg_hi1,
  input  logic [1:0]                cfg_comb,
  input  logic [2:0]                irq_en,
  input  logic [2:0]                flag_clr,
  output logic [2:0]                flags,
  output logic                      irq
);
  import awd_pkg::*;

  localparam int CH_W = $clog2(NUM_CH);

  logic [CH_W-1:0]   chan_a [NUM_UNITS];
  logic [DATA_W-1:0] lo_a   [NUM_UNITS];
  logic [DATA_W-1:0] hi_a   [NUM_UNITS];
  logic [NUM_UNITS-1:0] fire, hit;
  logic comb_set;
  logic [NUM_FLAGS-1:0] set_vec;

  assign chan_a[0] = cfg_chan0;
  assign chan_a[1] = cfg_chan1;
  assign lo_a[0]   = cfg_lo0;
  assign lo_a[1]   = cfg_lo1;
  assign hi_a[0]   = cfg_hi0;
  assign hi_a[1]   = cfg_hi1;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    awd_window_unit #(.DATA_W(DATA_W), .CH_W(CH_W)) u_win (
      .res_valid (res_valid),
      .res_chan  (res_chan),
      .res_value (res_value),
      .en        (cfg_unit_en[u]),
      .mode      (cfg_mode[u]),
      .chan_sel  (chan_a[u]),
      .lim_lo    (lo_a[u]),
      .lim_hi    (hi_a[u]),
      .fire      (fire[u]),
      .hit       (hit[u])
    );
  end

  awd_combiner u_comb (
    .clk      (clk),
    .rst      (rst),
    .fire0    (fire[0]),
    .hit0     (hit[0]),
    .fire1    (fire[1]),
    .hit1     (hit[1]),
    .fn       (cfg_comb),
    .comb_set (comb_set)
  );

  assign set_vec = {comb_set, hit};

  awd_flag_bank #(.NF(NUM_FLAGS)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_in  (set_vec),
    .clr     (flag_clr),
    .en      (irq_en),
    .flags_q (flags),
    .irq_q   (irq)
  );

  AST_U0_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!(res_valid && cfg_unit_en[0] && res_chan == cfg_chan0) && !flags[0]) |=> !flags[0]); // R4
  AST_U1_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!(res_valid && cfg_unit_en[1] && res_chan == cfg_chan1) && !flags[1]) |=> !flags[1]); // R4
  AST_COMB_OFF: assert property (@(posedge clk) disable iff (rst)
    (cfg_comb == 2'b00 && !flags[2]) |=> !flags[2]); // R7
  AST_COMB_NEEDS_U1: assert property (@(posedge clk) disable iff (rst)
    (!(res_valid && cfg_unit_en[1] && res_chan == cfg_chan1) && !flags[2]) |=> !flags[2]); // R8
endmodule

// File: tb/sim_awd_dual_monitor.sv
module sim_awd_dual_monitor;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic res_valid = 1'b0;
  logic [3:0] res_chan = '0;
  logic [15:0] res_value = '0;
  logic [1:0] cfg_unit_en = 2'b11;
  logic [1:0] cfg_mode = 2'b10;
  logic [3:0] cfg_chan0 = 4'd3, cfg_chan1 = 4'd5;
  logic [15:0] cfg_lo0 = 16'd100, cfg_hi0 = 16'd200;
  logic [15:0] cfg_lo1 = 16'd1000, cfg_hi1 = 16'd2000;
  logic [1:0] cfg_comb = 2'b00;
  logic [2:0] irq_en = 3'b000;
  logic [2:0] flag_clr = 3'b000;
  logic [2:0] flags;
  logic irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [2:0] m_flags = '0;
  logic m_irq = 1'b0;
  logic m_last0 = 1'b0;

  always #2 clk = ~clk;

  awd_dual_monitor u0 (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_chan(res_chan),
    .res_value(res_value), .cfg_unit_en(cfg_unit_en), .cfg_mode(cfg_mode),
    .cfg_chan0(cfg_chan0), .cfg_chan1(cfg_chan1), .cfg_lo0(cfg_lo0),
    .cfg_hi0(cfg_hi0), .cfg_lo1(cfg_lo1), .cfg_hi1(cfg_hi1),
    .cfg_comb(cfg_comb), .irq_en(irq_en), .flag_clr(flag_clr),
    .flags(flags), .irq(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic bit win_hit(logic [15:0] v, logic [15:0] lo, logic [15:0] hi, logic md);
    if (md) return (v > lo) && (v < hi);
    return (v > hi) || (v < lo);
  endfunction

  task automatic model_step();
    bit f0, f1, h0, h1, u0v, c;
    f0 = res_valid && cfg_unit_en[0] && (res_chan == cfg_chan0);
    f1 = res_valid && cfg_unit_en[1] && (res_chan == cfg_chan1);
    h0 = f0 && win_hit(res_value, cfg_lo0, cfg_hi0, cfg_mode[0]);
    h1 = f1 && win_hit(res_value, cfg_lo1, cfg_hi1, cfg_mode[1]);
    u0v = f0 ? h0 : m_last0;
    case (cfg_comb)
      2'b01: c = f1 && (u0v || h1);
      2'b10: c = f1 && (u0v && h1);
      2'b11: c = f1 && (u0v ^ h1);
      default: c = 1'b0;
    endcase
    if (rst) begin
      m_flags = '0; m_irq = 1'b0; m_last0 = 1'b0;
    end else begin
      m_flags = (m_flags & ~flag_clr) | {c, h1, h0};
      m_irq = |(m_flags & irq_en);
      if (f0) m_last0 = h0;
    end
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // R10: one edge from sampled stimulus to visible result
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(flags == m_flags, "R10 model flags", flags, m_flags);
    chk(irq == m_irq, "R10 model irq", irq, m_irq);
    res_valid = 1'b0;
    flag_clr = 3'b000;
  endtask

  task automatic step(bit v, int ch, int val, logic [2:0] clr,
                      logic [2:0] ef, bit ei, string req);
    res_valid = v;
    res_chan = ch[3:0];
    res_value = val[15:0];
    flag_clr = clr;
    tick();
    chk(flags == ef, req, flags, ef);
    chk(irq == ei, req, irq, ei);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    chk(flags == 3'b000 && irq == 1'b0, "R1 reset", {flags, irq}, 0);
    // R2 outside window, limits excluded
    step(1, 3, 200, 0, 3'b000, 0, "R2 at upper");
    step(1, 3, 100, 0, 3'b000, 0, "R2 at lower");
    step(1, 3, 201, 0, 3'b001, 0, "R2 above");
    step(0, 0, 0, 3'b001, 3'b000, 0, "R5 clear");
    step(1, 3, 99, 0, 3'b001, 0, "R2 below");
    step(1, 3, 50, 3'b001, 3'b001, 0, "R6 set beats clear");
    step(0, 0, 0, 3'b001, 3'b000, 0, "R5 clear");
    // R3 inside window, strict
    step(1, 5, 1000, 0, 3'b000, 0, "R3 at lower");
    step(1, 5, 2000, 0, 3'b000, 0, "R3 at upper");
    step(1, 5, 1001, 0, 3'b010, 0, "R3 inside");
    // R4 gating
    step(1, 4, 5, 0, 3'b010, 0, "R4 other channel");
    step(0, 3, 5, 0, 3'b010, 0, "R4 no strobe");
    cfg_unit_en = 2'b10;
    step(1, 3, 5, 0, 3'b010, 0, "R4 unit disabled");
    cfg_unit_en = 2'b11;
    step(1, 3, 300, 0, 3'b011, 0, "R2 set again");
    step(0, 0, 0, 3'b001, 3'b010, 0, "R5 clear one bit only");
    // R9 interrupt gating
    irq_en = 3'b010;
    step(0, 0, 0, 0, 3'b010, 1, "R9 enabled flag");
    irq_en = 3'b001;
    step(0, 0, 0, 0, 3'b010, 0, "R9 disabled flag");
    irq_en = 3'b000;
    step(0, 0, 0, 3'b111, 3'b000, 0, "R5 clear all");
    // R7 / R8 combination
    step(1, 3, 150, 0, 3'b000, 0, "R8 unit0 miss stored");
    cfg_comb = 2'b10;
    step(1, 5, 1500, 0, 3'b010, 0, "R7 AND with stale miss");
    step(0, 0, 0, 3'b111, 3'b000, 0, "R5 clear all");
    step(1, 3, 300, 0, 3'b001, 0, "R8 unit0 hit stored");
    step(1, 5, 1500, 0, 3'b111, 0, "R8 AND with stored hit");
    step(0, 0, 0, 3'b111, 3'b000, 0, "R5 clear all");
    cfg_comb = 2'b11;
    step(1, 5, 1500, 0, 3'b010, 0, "R7 XOR both hit");
    step(0, 0, 0, 3'b111, 3'b000, 0, "R5 clear all");
    step(1, 5, 5000, 0, 3'b100, 0, "R7 XOR one hit");
    step(0, 0, 0, 3'b111, 3'b000, 0, "R5 clear all");
    cfg_comb = 2'b01;
    step(1, 5, 5000, 0, 3'b100, 0, "R7 OR stored hit");
    step(0, 0, 0, 3'b111, 3'b000, 0, "R5 clear all");
    cfg_comb = 2'b00;
    step(1, 5, 5000, 0, 3'b000, 0, "R7 off");
    // R8 same channel: unit0 result of the same cycle is used
    cfg_chan1 = 4'd3; cfg_lo1 = 16'd120; cfg_hi1 = 16'd180; cfg_comb = 2'b10;
    step(1, 3, 150, 0, 3'b010, 0, "R8 same-cycle unit0 miss");
    // randomised run against the model
    for (int n = 0; n < 600; n++) begin
      if (n % 16 == 0) begin
        cfg_unit_en = 2'($urandom);
        cfg_mode = 2'($urandom);
        cfg_chan0 = 4'($urandom_range(0, 3));
        cfg_chan1 = 4'($urandom_range(0, 3));
        cfg_lo0 = 16'($urandom_range(10, 40));
        cfg_hi0 = 16'($urandom_range(40, 70));
        cfg_lo1 = 16'($urandom_range(10, 40));
        cfg_hi1 = 16'($urandom_range(40, 70));
        cfg_comb = 2'($urandom);
        irq_en = 3'($urandom);
      end
      res_valid = ($urandom_range(0, 3) != 0);
      res_chan = 4'($urandom_range(0, 4));
      res_value = 16'($urandom_range(5, 75));
      flag_clr = ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'b000;
      tick();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule